// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block is a small fully associative translation buffer. It keeps recently used mappings from virtual page numbers to physical frame numbers. Every slot also carries an address-space tag, so mappings that belong to several processes can sit in the buffer side by side. A lookup counts as a hit only when both the page number and the tag match the current address-space register. A tag mismatch is an ordinary miss. The core then fetches the mapping from the page table and writes it in through the refill port, and the retried lookup hits.

Lookups enter on a valid/ready request channel and are answered one cycle later on a response channel. The response has no back-pressure: it is valid for exactly one cycle, and the consumer must take it then. Three maintenance commands are plain pins: refill, single-page invalidate and flush-all. The request channel drops `req_ready` in any cycle where one of them is raised. When all slots hold valid mappings, a refill replaces the least recently used slot. Changing the current tag leaves all other processes' slots valid.

Top module: `asid_tlb`

## Requirements
- R1: Out of reset every slot is invalid, `rsp_valid` is 0 and `req_ready` is 1. The first lookup after reset misses.
- R2: A request accepted at a clock edge (`req_valid` and `req_ready` both 1) gives exactly one response on the next edge. `rsp_valid` is 1 only in that case.
- R3: A lookup hits only if a valid slot holds the requested page number and a tag equal to `cur_asid` in the request cycle. Any other lookup gives `rsp_hit`=0 and `rsp_miss`=1, and no fault of any kind.
- R4: After a refill of (page, tag, frame), a lookup of that page under that tag hits and returns that frame.
- R5: A refill whose page and tag match a valid slot overwrites that slot, so no duplicate is made and no other slot is evicted.
- R6: A refill with no matching slot uses the lowest-numbered invalid slot. If all slots are valid, it evicts the least recently used slot.
- R7: Recency changes only on a lookup hit or on a refill, and the touched slot becomes most recent. Misses, invalidates and flushes leave the order unchanged.
- R8: Invalidate of (page, tag) clears only the slot matching both, so the next lookup of that pair misses.
- R9: Flush-all clears every valid bit.
- R10: Changing `cur_asid` invalidates nothing. Switching back to an earlier tag hits on its old slots.
- R11: A raised `flush_all`, `inv_valid` or `fill_valid` pulls `req_ready` low in that cycle. If several are raised together, flush takes precedence over invalidate, and invalidate over refill. Only the winning command takes effect.
- R12: On a miss, `rsp_pfn` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_asid | input | 8 | Address-space tag of the running process |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup accepted this cycle |
| req_vpn | input | 20 | Virtual page number to translate |
| rsp_valid | output | 1 | Response for the request accepted on the previous edge |
| rsp_hit | output | 1 | Translation found |
| rsp_miss | output | 1 | Translation absent, refill wanted |
| rsp_pfn | output | 20 | Frame number on a hit, zero on a miss |
| fill_valid | input | 1 | Write a translation |
| fill_vpn | input | 20 | Page number to write |
| fill_asid | input | 8 | Tag to write |
| fill_pfn | input | 20 | Frame number to write |
| inv_valid | input | 1 | Invalidate one page |
| inv_vpn | input | 20 | Page number to invalidate |
| inv_asid | input | 8 | Tag of the page to invalidate |
| flush_all | input | 1 | Clear all slots |

## Verification
Some properties are checked on every cycle by assertions. These are: at most one slot matching a lookup, the response timing after an accepted request, a zero frame on a miss, the empty state after a flush, a single oldest slot in the recency order, and no change to that order without a touch. The bench scenarios cover what needs history: refill-then-hit, overwrite in place, choice of eviction slot after particular hit and miss patterns, tag-selective invalidate, survival of slots across tag switches, and command precedence. A random phase compares every response against a reference model.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_FILL  = 2'd1,
    OP_INVAL = 2'd2,
    OP_FLUSH = 2'd3
  } maint_op_e;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int unsigned N      = 8,
  parameter int unsigned VPN_W  = 20,
  parameter int unsigned ASID_W = 8
) (
  input  logic [N-1:0]             slot_v,
  input  logic [N-1:0][VPN_W-1:0]  slot_vpn,
  input  logic [N-1:0][ASID_W-1:0] slot_asid,
  input  logic [VPN_W-1:0]         key_vpn,
  input  logic [ASID_W-1:0]        key_asid,
  output logic [N-1:0]             hit_vec
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = slot_v[g] && (slot_vpn[g] == key_vpn) && (slot_asid[g] == key_asid);
  end
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
  parameter int unsigned N  = 8,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          touch,
  input  logic [IW-1:0] touch_idx,
  output logic [IW-1:0] victim_idx
);
  logic [N-1:0][IW-1:0] age_q;
  logic [N-1:0]         oldest;

  for (genvar g = 0; g < N; g++) begin : g_old
    assign oldest[g] = (age_q[g] == IW'(N - 1));
  end

  always_comb begin
    victim_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (oldest[i]) victim_idx = IW'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) age_q[i] <= IW'(i);
    end else if (touch) begin
      for (int i = 0; i < N; i++) begin
        if (IW'(i) == touch_idx) age_q[i] <= '0;
        else if (age_q[i] < age_q[touch_idx]) age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  p_one_oldest_r6: assert property (@(posedge clk) disable iff (!rst_n) $onehot(oldest))
    else $error("recency order lost its single oldest slot");
  p_age_hold_r7: assert property (@(posedge clk) disable iff (!rst_n) !touch |=> $stable(age_q))
    else $error("recency changed without a touch");
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb #(
  parameter int unsigned N      = 8,
  parameter int unsigned VPN_W  = 20,
  parameter int unsigned PFN_W  = 20,
  parameter int unsigned ASID_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VPN_W-1:0]  req_vpn,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic [PFN_W-1:0]  rsp_pfn,
  input  logic              fill_valid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic              inv_valid,
  input  logic [VPN_W-1:0]  inv_vpn,
  input  logic [ASID_W-1:0] inv_asid,
  input  logic              flush_all
);
  import tlb_pkg::*;
  localparam int unsigned IW = $clog2(N);

  logic [N-1:0]             v_q;
  logic [N-1:0][VPN_W-1:0]  vpn_q;
  logic [N-1:0][PFN_W-1:0]  pfn_q;
  logic [N-1:0][ASID_W-1:0] asid_q;

  maint_op_e         op;
  logic [VPN_W-1:0]  mkey_vpn;
  logic [ASID_W-1:0] mkey_asid;
  logic [N-1:0]      lk_hit_vec, mt_hit_vec;
  logic [IW-1:0]     lk_idx, mt_idx, free_idx, victim_idx, fill_idx;
  logic [PFN_W-1:0]  lk_pfn;
  logic              lk_any, free_any, lookup_fire, touch;
  logic [IW-1:0]     touch_idx;

  always_comb begin
    if (flush_all)       op = OP_FLUSH;
    else if (inv_valid)  op = OP_INVAL;
    else if (fill_valid) op = OP_FILL;
    else                 op = OP_NONE;
  end

  assign mkey_vpn  = (op == OP_INVAL) ? inv_vpn  : fill_vpn;
  assign mkey_asid = (op == OP_INVAL) ? inv_asid : fill_asid;

  tlb_match #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lk_match (
    .slot_v(v_q), .slot_vpn(vpn_q), .slot_asid(asid_q),
    .key_vpn(req_vpn), .key_asid(cur_asid), .hit_vec(lk_hit_vec));

  tlb_match #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_mt_match (
    .slot_v(v_q), .slot_vpn(vpn_q), .slot_asid(asid_q),
    .key_vpn(mkey_vpn), .key_asid(mkey_asid), .hit_vec(mt_hit_vec));

  always_comb begin
    lk_pfn = '0;
    lk_idx = '0;
    mt_idx = '0;
    for (int i = 0; i < N; i++) begin
      lk_pfn = lk_pfn | (pfn_q[i] & {PFN_W{lk_hit_vec[i]}});
      if (lk_hit_vec[i]) lk_idx = IW'(i);
      if (mt_hit_vec[i]) mt_idx = IW'(i);
    end
    free_idx = '0;
    free_any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!v_q[i]) begin
        free_idx = IW'(i);
        free_any = 1'b1;
      end
    end
  end

  assign lk_any = |lk_hit_vec;

  always_comb begin
    if (|mt_hit_vec)   fill_idx = mt_idx;
    else if (free_any) fill_idx = free_idx;
    else               fill_idx = victim_idx;
  end

  assign req_ready   = (op == OP_NONE);
  assign lookup_fire = req_valid && req_ready;
  assign touch       = (op == OP_FILL) || (lookup_fire && lk_any);
  assign touch_idx   = (op == OP_FILL) ? fill_idx : lk_idx;

  tlb_lru #(.N(N)) u_lru (
    .clk(clk), .rst_n(rst_n), .touch(touch), .touch_idx(touch_idx), .victim_idx(victim_idx));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q <= '0;
    end else begin
      case (op)
        OP_FLUSH: v_q <= '0;
        OP_INVAL: v_q <= v_q & ~mt_hit_vec;
        OP_FILL:  v_q[fill_idx] <= 1'b1;
        default:  v_q <= v_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (op == OP_FILL) begin
      vpn_q[fill_idx]  <= fill_vpn;
      pfn_q[fill_idx]  <= fill_pfn;
      asid_q[fill_idx] <= fill_asid;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_pfn   <= '0;
    end else begin
      rsp_valid <= lookup_fire;
      rsp_hit   <= lookup_fire && lk_any;
      rsp_pfn   <= lookup_fire ? lk_pfn : '0;
    end
  end

  assign rsp_miss = rsp_valid && !rsp_hit;

  p_one_match_r5: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(lk_hit_vec))
    else $error("duplicate slots for one page and tag");
  p_rsp_timing_r2: assert property (@(posedge clk) disable iff (!rst_n)
      lookup_fire |=> rsp_valid)
    else $error("accepted request gave no response");
  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !lookup_fire |=> !rsp_valid)
    else $error("response without accepted request");
  p_miss_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_miss |-> (rsp_pfn == '0))
    else $error("miss returned a nonzero frame");
  p_flush_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      flush_all |=> (v_q == '0))
    else $error("flush left a valid slot");
endmodule

// File: tb/asid_tlb_tb.sv
module asid_tlb_tb;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0]  cur_asid = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [19:0] req_vpn = '0;
  logic        rsp_valid, rsp_hit, rsp_miss;
  logic [19:0] rsp_pfn;
  logic        fill_valid = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [7:0]  fill_asid = '0;
  logic [19:0] fill_pfn = '0;
  logic        inv_valid = 1'b0;
  logic [19:0] inv_vpn = '0;
  logic [7:0]  inv_asid = '0;
  logic        flush_all = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  bit          m_v   [N];
  logic [19:0] m_vpn [N];
  logic [19:0] m_pfn [N];
  logic [7:0]  m_asid[N];
  int          m_age [N];

  always #2.5 clk = ~clk;

  asid_tlb u_dut (
    .clk(clk), .rst_n(rst_n), .cur_asid(cur_asid),
    .req_valid(req_valid), .req_ready(req_ready), .req_vpn(req_vpn),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_pfn(rsp_pfn),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_asid(fill_asid), .fill_pfn(fill_pfn),
    .inv_valid(inv_valid), .inv_vpn(inv_vpn), .inv_asid(inv_asid), .flush_all(flush_all));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic int m_find(logic [19:0] vpn, logic [7:0] asid);
    for (int i = 0; i < N; i++)
      if (m_v[i] && m_vpn[i] == vpn && m_asid[i] == asid) return i;
    return -1;
  endfunction

  function automatic int m_victim();
    for (int i = 0; i < N; i++) if (!m_v[i]) return i;
    for (int i = 0; i < N; i++) if (m_age[i] == N - 1) return i;
    return 0;
  endfunction

  function automatic void m_touch(int idx);
    for (int j = 0; j < N; j++)
      if (j != idx && m_age[j] < m_age[idx]) m_age[j]++;
    m_age[idx] = 0;
  endfunction

  function automatic void m_reset();
    for (int i = 0; i < N; i++) begin
      m_v[i] = 1'b0;
      m_age[i] = i;
    end
  endfunction

  task automatic lookup(string tag, logic [19:0] vpn);
    int idx;
    idx = m_find(vpn, cur_asid);
    req_valid = 1'b1;
    req_vpn   = vpn;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " rsp_valid"}, 32'(rsp_valid), 32'd1);
    chk({tag, " hit"}, 32'(rsp_hit), 32'(idx >= 0));
    chk({tag, " miss"}, 32'(rsp_miss), 32'(idx < 0));
    chk({tag, " pfn"}, 32'(rsp_pfn), (idx >= 0) ? 32'(m_pfn[idx]) : 32'd0);
    if (idx >= 0) m_touch(idx);
  endtask

  task automatic fill(logic [19:0] vpn, logic [7:0] asid, logic [19:0] pfn);
    int idx;
    idx = m_find(vpn, asid);
    if (idx < 0) idx = m_victim();
    fill_valid = 1'b1;
    fill_vpn = vpn; fill_asid = asid; fill_pfn = pfn;
    @(negedge clk);
    fill_valid = 1'b0;
    m_v[idx] = 1'b1; m_vpn[idx] = vpn; m_asid[idx] = asid; m_pfn[idx] = pfn;
    m_touch(idx);
  endtask

  task automatic inval(logic [19:0] vpn, logic [7:0] asid);
    int idx;
    idx = m_find(vpn, asid);
    inv_valid = 1'b1; inv_vpn = vpn; inv_asid = asid;
    @(negedge clk);
    inv_valid = 1'b0;
    if (idx >= 0) m_v[idx] = 1'b0;
  endtask

  task automatic flush();
    flush_all = 1'b1;
    @(negedge clk);
    flush_all = 1'b0;
    for (int i = 0; i < N; i++) m_v[i] = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 rsp_valid idle", 32'(rsp_valid), 32'd0);
    chk("R1 req_ready idle", 32'(req_ready), 32'd1);
    lookup("R1 first lookup", 20'h00010);
    @(negedge clk);
    chk("R2 single response", 32'(rsp_valid), 32'd0);

    // R4 refill then retry hits; R12 zero frame on miss
    cur_asid = 8'd1;
    lookup("R12 miss before fill", 20'h12345);
    fill(20'h12345, 8'd1, 20'hABCDE);
    lookup("R4 retry hits", 20'h12345);

    // R3 / R10 tag matching and survival across switches
    fill(20'h12345, 8'd2, 20'h11111);
    cur_asid = 8'd2;
    lookup("R3 tag 2 frame", 20'h12345);
    cur_asid = 8'd1;
    lookup("R10 tag 1 survives", 20'h12345);
    cur_asid = 8'd3;
    lookup("R3 foreign tag misses", 20'h12345);

    // R8 tag-selective invalidate
    inval(20'h12345, 8'd1);
    cur_asid = 8'd1;
    lookup("R8 invalidated misses", 20'h12345);
    cur_asid = 8'd2;
    lookup("R8 other tag kept", 20'h12345);

    // R9 flush
    flush();
    lookup("R9 flushed misses", 20'h12345);

    // R6 / R7: fill all slots, touch one, miss does not touch
    cur_asid = 8'd4;
    for (int i = 0; i < N; i++) fill(20'(i), 8'd4, 20'(16'h100 + i));
    lookup("R7 hit touches slot 0", 20'd0);
    lookup("R7 miss no touch", 20'd99);
    fill(20'd8, 8'd4, 20'h00777);
    lookup("R6 oldest evicted", 20'd1);
    chk("R6 page 1 gone", 32'(rsp_hit), 32'd0);
    lookup("R6 recent kept", 20'd0);
    chk("R6 page 0 kept", 32'(rsp_hit), 32'd1);

    // R5 overwrite in place
    fill(20'd2, 8'd4, 20'h0BEEF);
    lookup("R5 new frame", 20'd2);
    chk("R5 new frame value", 32'(rsp_pfn), 32'h0BEEF);
    for (int i = 3; i < N + 1; i++) lookup("R5 no eviction", 20'(i));

    // R11 command precedence and ready
    req_valid = 1'b1; req_vpn = 20'd0;
    fill_valid = 1'b1; fill_vpn = 20'h55; fill_asid = 8'd4; fill_pfn = 20'h9;
    flush_all = 1'b1;
    #1;
    chk("R11 ready low", 32'(req_ready), 32'd0);
    @(negedge clk);
    req_valid = 1'b0; fill_valid = 1'b0; flush_all = 1'b0;
    chk("R11 no response", 32'(rsp_valid), 32'd0);
    for (int i = 0; i < N; i++) m_v[i] = 1'b0;
    lookup("R11 fill lost to flush", 20'h55);
    fill(20'h66, 8'd4, 20'h1);
    inv_valid = 1'b1; inv_vpn = 20'h66; inv_asid = 8'd4;
    fill_valid = 1'b1; fill_vpn = 20'h77; fill_asid = 8'd4; fill_pfn = 20'h2;
    @(negedge clk);
    inv_valid = 1'b0; fill_valid = 1'b0;
    m_v[m_find(20'h66, 8'd4)] = 1'b0;
    lookup("R11 inval wins", 20'h66);
    lookup("R11 fill dropped", 20'h77);

    // random phase against the model
    void'($urandom(32'd2024));
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = int'($urandom % 20);
      if (r < 8) lookup("R3 random lookup", 20'($urandom % 12));
      else if (r < 13) fill(20'($urandom % 12), 8'($urandom % 3), 20'($urandom));
      else if (r < 15) inval(20'($urandom % 12), 8'($urandom % 3));
      else if (r < 19) begin
        cur_asid = 8'($urandom % 3);
        lookup("R10 random switch", 20'($urandom % 12));
      end else if (($urandom % 8) == 0) flush();
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule